// File: doc/BRIEF.md
# Spread-Spectrum Offset Profile Generator

This block generates the digital frequency-offset sequence that spreads a synthesized clock so that its emitted energy is less concentrated. While enabled it walks a signed offset word between a lower and an upper bound, one step per dwell interval. The step interval is measured in reference ticks of 280 ns each. The offset feeds the feedback-divider path of a synthesizer. The analog side of the loop is outside this block.

Four presets set the bounds: two down-spread presets, whose offset never rises above zero, and two center-spread presets, whose range is symmetric about zero. Two profile shapes are available. The original shape climbs from the lower bound to the upper bound and falls back. The pendulum shape starts at the midpoint, swings to the top, then to the bottom, and returns to the midpoint. The rising and falling step sizes are programmed separately. The falling step field is written as a negative two's-complement number. The block samples its settings when it starts and again at each period boundary, so a period is never distorted by a change made part-way through it.

One offset unit is 1/QUARTER of a quarter percent. With the default QUARTER of 16, a 1% spread spans 64 units.

Top module: `ssm_spread_gen`

## Requirements
- R1: After synchronous reset, ofs_o is 0 and rising_o and wrap_o are 0.
- R2: While ss_en_i is 0, ofs_o is 0 and rising_o and wrap_o are 0, whatever the other inputs do. ofs_o returns to 0 one clock after ss_en_i falls. When ss_en_i rises again, the profile restarts at its start value on the next clock.
- R3: ss_kind_i selects the bounds [lo, hi], with Q = QUARTER: 00 gives [-4Q, 0] (1% down), 01 gives [-2Q, 0] (0.5% down), 10 gives [-2Q, +2Q] (±0.5% center), 11 gives [-Q, +Q] (±0.25% center). The midpoint is (lo+hi)/2. ofs_o never leaves [-4Q, +2Q], and every profile reaches both of its bounds.
- R4: With pend_i = 0 (original shape), a period starts at lo, rises to hi, and then falls back to lo.
- R5: With pend_i = 1 (pendulum shape), a period starts at the midpoint, rises to hi, falls to lo, and then rises back to the midpoint.
- R6: A rising step adds the unsigned value of up_step_i, with 0000 meaning 16. A step that would pass the current target lands exactly on it, and the next phase begins. No step changes ofs_o by more than 16.
- R7: The falling step size is the negation of dn_step_i read as 4-bit two's complement, taken modulo 16 with 0 meaning 16. So 1111 gives 1, 1110 gives 2, 1000 gives 8, 0111 gives 9 and 0000 gives 16.
- R8: While running, ofs_o changes only on a clock where tick_i is 1, and consecutive steps are exactly dwell_i+1 ticks apart.
- R9: wrap_o is a single-cycle pulse in the cycle in which ofs_o returns to the start value and completes a period.
- R10: The preset, shape, step sizes and dwell are captured when the block starts after enable and again at each period boundary. A change made mid-period takes effect at the next boundary, and ofs_o moves at that boundary to the new start value.
- R11: rising_o is 1 while running and the current phase moves upward, so it gives the direction of the next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ss_en_i | input | 1 | Spreading enable |
| ss_kind_i | input | 2 | Preset select (bounds) |
| pend_i | input | 1 | Profile shape: 1 pendulum, 0 original |
| up_step_i | input | 4 | Rising step size, 0 means 16 |
| dn_step_i | input | 4 | Falling step size as negative two's complement |
| dwell_i | input | 6 | Ticks per step minus one |
| tick_i | input | 1 | Reference tick, 280 ns resolution |
| ofs_o | output | OFS_W | Signed frequency offset |
| rising_o | output | 1 | Current phase moves upward |
| wrap_o | output | 1 | Period-complete pulse |

## Verification
The main function is tried with every preset, each under one of the two shapes. The step sizes are chosen so that some ramps land exactly on a bound and others have to be clipped, which separates correct clipping from overshoot. Step fields of 0000 and of 1000/0111 separate the 16-wide wrap of the size fields from a plain unsigned reading, and 1111/1110 confirm the negated encoding of the falling step. One run keeps the reset settings with the long dwell, and one changes the preset part-way through a period, which shows whether settings are captured only at the boundary. A run with enable low and inputs toggling, and a disable and re-enable in mid-profile, show that the output is cleared and the profile restarts.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

    localparam int STEP_W  = 4;
    localparam int DWELL_W = 6;

    typedef enum logic [1:0] {
        KIND_DN100 = 2'b00,
        KIND_DN050 = 2'b01,
        KIND_CT050 = 2'b10,
        KIND_CT025 = 2'b11
    } ss_kind_e;

    typedef enum logic [1:0] {
        PH_TO_HI  = 2'd0,
        PH_TO_LO  = 2'd1,
        PH_TO_MID = 2'd2
    } ss_phase_e;

    typedef struct packed {
        ss_kind_e             kind;
        logic                 pend;
        logic [STEP_W-1:0]    up_f;
        logic [STEP_W-1:0]    dn_f;
        logic [DWELL_W-1:0]   dwell;
    } ss_cfg_t;

    localparam ss_cfg_t CFG_RESET = '{
        kind:  KIND_CT025,
        pend:  1'b1,
        up_f:  STEP_W'(1),
        dn_f:  {STEP_W{1'b1}},
        dwell: DWELL_W'(39)
    };

    // Rising magnitude: unsigned field, zero stands for the full 2^STEP_W.
    function automatic logic [STEP_W:0] up_mag(input logic [STEP_W-1:0] f);
        return (f == '0) ? (STEP_W+1)'(1 << STEP_W) : {1'b0, f};
    endfunction

    // Falling magnitude: negation of a two's-complement field, modulo 2^STEP_W,
    // with zero again standing for 2^STEP_W.
    function automatic logic [STEP_W:0] dn_mag(input logic [STEP_W-1:0] f);
        return {1'b0, ~f} + (STEP_W+1)'(1);
    endfunction

    function automatic int lo_quarters(input ss_kind_e k);
        case (k)
            KIND_DN100: return -4;
            KIND_DN050: return -2;
            KIND_CT050: return -2;
            default:    return -1;
        endcase
    endfunction

    function automatic int hi_quarters(input ss_kind_e k);
        case (k)
            KIND_DN100: return 0;
            KIND_DN050: return 0;
            KIND_CT050: return 2;
            default:    return 1;
        endcase
    endfunction

endpackage

// File: rtl/ssm_bounds.sv
module ssm_bounds
    import ssm_pkg::*;
#(
    parameter int OFS_W   = 12,
    parameter int QUARTER = 16
) (
    input  ss_cfg_t                  cfg,
    output logic signed [OFS_W-1:0]  lo_o,
    output logic signed [OFS_W-1:0]  hi_o,
    output logic signed [OFS_W-1:0]  mid_o,
    output logic signed [OFS_W-1:0]  start_o
);

    int lo_i;
    int hi_i;

    always_comb begin
        lo_i    = lo_quarters(cfg.kind) * QUARTER;
        hi_i    = hi_quarters(cfg.kind) * QUARTER;
        lo_o    = OFS_W'(lo_i);
        hi_o    = OFS_W'(hi_i);
        mid_o   = OFS_W'((lo_i + hi_i) / 2);
        start_o = cfg.pend ? OFS_W'((lo_i + hi_i) / 2) : OFS_W'(lo_i);
    end

endmodule

// File: rtl/ssm_cfg_reg.sv
module ssm_cfg_reg
    import ssm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load_i,
    input  ss_cfg_t cfg_i,
    output ss_cfg_t cfg_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_o <= CFG_RESET;
        end else if (load_i) begin
            cfg_o <= cfg_i;
        end
    end

endmodule

// File: rtl/ssm_dwell_timer.sv
module ssm_dwell_timer #(
    parameter int DW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_i,
    input  logic          tick_i,
    input  logic [DW-1:0] dwell_i,
    output logic          step_o
);

    logic [DW-1:0] cnt_q;
    logic          at_end;

    assign at_end = (cnt_q == dwell_i);
    assign step_o = run_i && tick_i && at_end;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/ssm_profile_core.sv
module ssm_profile_core
    import ssm_pkg::*;
#(
    parameter int OFS_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en_i,
    input  logic                    step_i,
    input  logic                    pend_i,
    input  logic [STEP_W:0]         up_mag_i,
    input  logic [STEP_W:0]         dn_mag_i,
    input  logic signed [OFS_W-1:0] lo_i,
    input  logic signed [OFS_W-1:0] hi_i,
    input  logic signed [OFS_W-1:0] mid_i,
    input  logic signed [OFS_W-1:0] start_next_i,
    output logic                    load_o,
    output logic                    run_o,
    output logic signed [OFS_W-1:0] ofs_o,
    output logic                    rising_o,
    output logic                    wrap_o
);

    localparam int XW = OFS_W + 1;

    logic                    run_q;
    ss_phase_e               ph_q;
    ss_phase_e               ph_nxt;
    logic signed [OFS_W-1:0] ofs_q;
    logic                    wrap_q;

    logic signed [OFS_W-1:0] tgt;
    logic signed [XW-1:0]    cur_x;
    logic signed [XW-1:0]    tgt_x;
    logic signed [XW-1:0]    up_x;
    logic signed [XW-1:0]    dn_x;
    logic signed [XW-1:0]    cand_x;
    logic                    up_ph;
    logic                    reach;
    logic                    last_ph;
    logic                    wrap_now;

    assign cur_x = XW'(ofs_q);
    assign up_x  = XW'($signed({1'b0, up_mag_i}));
    assign dn_x  = XW'($signed({1'b0, dn_mag_i}));

    always_comb begin
        case (ph_q)
            PH_TO_HI: tgt = hi_i;
            PH_TO_LO: tgt = lo_i;
            default:  tgt = mid_i;
        endcase
        tgt_x   = XW'(tgt);
        up_ph   = (ph_q != PH_TO_LO);
        cand_x  = up_ph ? (cur_x + up_x) : (cur_x - dn_x);
        reach   = up_ph ? (cand_x >= tgt_x) : (cand_x <= tgt_x);
        last_ph = pend_i ? (ph_q == PH_TO_MID) : (ph_q == PH_TO_LO);
        case (ph_q)
            PH_TO_HI: ph_nxt = PH_TO_LO;
            default:  ph_nxt = PH_TO_MID;
        endcase
    end

    assign wrap_now = run_q && step_i && reach && last_ph;
    assign load_o   = en_i && (!run_q || wrap_now);

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            run_q  <= 1'b0;
            ph_q   <= PH_TO_HI;
            ofs_q  <= '0;
            wrap_q <= 1'b0;
        end else if (load_o) begin
            run_q  <= 1'b1;
            ph_q   <= PH_TO_HI;
            ofs_q  <= start_next_i;
            wrap_q <= run_q;
        end else if (step_i) begin
            wrap_q <= 1'b0;
            if (reach) begin
                ofs_q <= tgt;
                ph_q  <= ph_nxt;
            end else begin
                ofs_q <= cand_x[OFS_W-1:0];
            end
        end else begin
            wrap_q <= 1'b0;
        end
    end

    assign run_o    = run_q;
    assign ofs_o    = ofs_q;
    assign wrap_o   = wrap_q;
    assign rising_o = run_q && up_ph;

endmodule

// File: rtl/ssm_spread_gen.sv
module ssm_spread_gen
    import ssm_pkg::*;
#(
    parameter int OFS_W   = 12,
    parameter int QUARTER = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ss_en_i,
    input  logic [1:0]              ss_kind_i,
    input  logic                    pend_i,
    input  logic [STEP_W-1:0]       up_step_i,
    input  logic [STEP_W-1:0]       dn_step_i,
    input  logic [DWELL_W-1:0]      dwell_i,
    input  logic                    tick_i,
    output logic signed [OFS_W-1:0] ofs_o,
    output logic                    rising_o,
    output logic                    wrap_o
);

    localparam int N_BND = 2;   // index 0: captured settings, 1: incoming settings

    ss_cfg_t                 cfg_in;
    ss_cfg_t                 cfg_q;
    ss_cfg_t                 cfg_sel [N_BND];
    logic signed [OFS_W-1:0] lo_a    [N_BND];
    logic signed [OFS_W-1:0] hi_a    [N_BND];
    logic signed [OFS_W-1:0] mid_a   [N_BND];
    logic signed [OFS_W-1:0] start_a [N_BND];
    logic                    load_w;
    logic                    run_w;
    logic                    step_w;

    assign cfg_in = '{
        kind:  ss_kind_e'(ss_kind_i),
        pend:  pend_i,
        up_f:  up_step_i,
        dn_f:  dn_step_i,
        dwell: dwell_i
    };

    assign cfg_sel[0] = cfg_q;
    assign cfg_sel[1] = cfg_in;

    ssm_cfg_reg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load_i (load_w),
        .cfg_i  (cfg_in),
        .cfg_o  (cfg_q)
    );

    for (genvar g = 0; g < N_BND; g++) begin : g_bnd
        ssm_bounds #(
            .OFS_W   (OFS_W),
            .QUARTER (QUARTER)
        ) u_bnd (
            .cfg     (cfg_sel[g]),
            .lo_o    (lo_a[g]),
            .hi_o    (hi_a[g]),
            .mid_o   (mid_a[g]),
            .start_o (start_a[g])
        );
    end

    ssm_dwell_timer #(
        .DW (DWELL_W)
    ) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .run_i   (run_w),
        .tick_i  (tick_i),
        .dwell_i (cfg_q.dwell),
        .step_o  (step_w)
    );

    ssm_profile_core #(
        .OFS_W (OFS_W)
    ) u_core (
        .clk          (clk),
        .rst          (rst),
        .en_i         (ss_en_i),
        .step_i       (step_w),
        .pend_i       (cfg_q.pend),
        .up_mag_i     (up_mag(cfg_q.up_f)),
        .dn_mag_i     (dn_mag(cfg_q.dn_f)),
        .lo_i         (lo_a[0]),
        .hi_i         (hi_a[0]),
        .mid_i        (mid_a[0]),
        .start_next_i (start_a[1]),
        .load_o       (load_w),
        .run_o        (run_w),
        .ofs_o        (ofs_o),
        .rising_o     (rising_o),
        .wrap_o       (wrap_o)
    );

endmodule

// File: rtl/ssm_spread_chk.sv
module ssm_spread_chk
    import ssm_pkg::*;
#(
    parameter int OFS_W   = 12,
    parameter int QUARTER = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    ss_en_i,
    input logic                    tick_i,
    input logic                    run_q,
    input logic signed [OFS_W-1:0] ofs_o,
    input logic                    wrap_o
);

    localparam int LO_LIM   = -4 * QUARTER;
    localparam int HI_LIM   = 2 * QUARTER;
    localparam int MAX_STEP = 1 << STEP_W;

    // R2: disabling clears the offset on the next clock
    p_zero_when_off_r2: assert property (@(posedge clk) disable iff (rst)
        !ss_en_i |=> (ofs_o == '0));

    // R3: offset stays inside the widest preset range
    p_range_r3: assert property (@(posedge clk) disable iff (rst)
        (ofs_o >= LO_LIM) && (ofs_o <= HI_LIM));

    // R6: a step inside a period moves by at most one full step size
    p_step_size_r6: assert property (@(posedge clk) disable iff (rst)
        (run_q && $past(run_q) && !wrap_o) |->
            (((ofs_o - $past(ofs_o)) <= MAX_STEP) && (($past(ofs_o) - ofs_o) <= MAX_STEP)));

    // R8: no tick, no movement while running
    p_hold_between_ticks_r8: assert property (@(posedge clk) disable iff (rst)
        (run_q && ss_en_i && !tick_i) |=> $stable(ofs_o));

    // R9: the period marker lasts one cycle
    p_wrap_single_r9: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> !wrap_o);

endmodule

bind ssm_spread_gen ssm_spread_chk #(
    .OFS_W   (OFS_W),
    .QUARTER (QUARTER)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ss_en_i (ss_en_i),
    .tick_i  (tick_i),
    .run_q   (run_w),
    .ofs_o   (ofs_o),
    .wrap_o  (wrap_o)
);

// File: tb/sim_ssm_spread_gen.sv
module sim_ssm_spread_gen;

    localparam int CLK_P = 10;
    localparam int TDIV  = 4;
    localparam int OFS_W = 12;
    localparam int QU    = 16;

    logic                    clk = 1'b0;
    logic                    rst;
    logic                    ss_en;
    logic [1:0]              kind;
    logic                    pend;
    logic [3:0]              up_f;
    logic [3:0]              dn_f;
    logic [5:0]              dwell;
    logic                    tick;
    logic signed [OFS_W-1:0] ofs;
    logic                    rising;
    logic                    wrap;

    int n_chk = 0;
    int n_err = 0;

    // scoreboard state
    int    q[$];
    int    per[$];
    bit    mon_on = 0;
    int    prev, cyc, idx, wraps, mn, mx;
    int    skip_iv, skip_dir, iv_exp, exp_wrap, iv_err, dir_err;
    bit    last_rise;
    string run_tag = "";

    ssm_spread_gen #(.OFS_W(OFS_W), .QUARTER(QU)) u0 (
        .clk       (clk),
        .rst       (rst),
        .ss_en_i   (ss_en),
        .ss_kind_i (kind),
        .pend_i    (pend),
        .up_step_i (up_f),
        .dn_step_i (dn_f),
        .dwell_i   (dwell),
        .tick_i    (tick),
        .ofs_o     (ofs),
        .rising_o  (rising),
        .wrap_o    (wrap)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // R3 bounds table, Q = 16
    function automatic int b_lo(input int k);
        case (k) 0: return -4*QU; 1: return -2*QU; 2: return -2*QU; default: return -QU; endcase
    endfunction
    function automatic int b_hi(input int k);
        case (k) 0: return 0; 1: return 0; 2: return 2*QU; default: return QU; endcase
    endfunction
    // R6 / R7 magnitudes
    function automatic int m_up(input int f); return (f == 0) ? 16 : f; endfunction
    function automatic int m_dn(input int f); return (f == 0) ? 16 : 16 - f; endfunction

    task automatic gen_period(input int lo, input int hi, input int pd, input int u, input int d);
        int v;
        int md;
        md = (lo + hi) / 2;
        per.delete();
        v = pd ? md : lo;
        while (v < hi) begin v = (v + u > hi) ? hi : v + u; per.push_back(v); end
        while (v > lo) begin v = (v - d < lo) ? lo : v - d; per.push_back(v); end
        if (pd) while (v < md) begin v = (v + u > md) ? md : v + u; per.push_back(v); end
    endtask

    task automatic tick_clk();
        @(posedge clk); #1;
    endtask

    // driver: pushes expected offsets, runs settings A, switches inputs to B
    task automatic do_run(input int ka, input int pa, input int ua, input int da, input int wa,
                          input int kb, input int pb, input int ub, input int db,
                          input int nb, input string tag);
        int st_a, st_b, waited;
        st_a = pa ? (b_lo(ka) + b_hi(ka)) / 2 : b_lo(ka);
        st_b = pb ? (b_lo(kb) + b_hi(kb)) / 2 : b_lo(kb);
        kind = 2'(ka); pend = pa[0]; up_f = 4'(ua); dn_f = 4'(da); dwell = 6'(wa);
        q.delete();
        if (st_a != 0) q.push_back(st_a);
        gen_period(b_lo(ka), b_hi(ka), pa, m_up(ua), m_dn(da));
        per[per.size()-1] = st_b;
        foreach (per[i]) q.push_back(per[i]);
        for (int n = 0; n < nb; n++) begin
            gen_period(b_lo(kb), b_hi(kb), pb, m_up(ub), m_dn(db));
            foreach (per[i]) q.push_back(per[i]);
        end
        prev = 0; cyc = 0; idx = 0; wraps = 0; mn = 0; mx = 0;
        skip_iv = (st_a != 0) ? 2 : 1; skip_dir = (st_a != 0) ? 1 : 0;
        iv_exp = (wa + 1) * TDIV; exp_wrap = st_b; iv_err = 0; dir_err = 0;
        run_tag = tag; mon_on = 1;
        ss_en = 1'b1;
        tick_clk();
        kind = 2'(kb); pend = pb[0]; up_f = 4'(ub); dn_f = 4'(db);
        waited = 0;
        while (q.size() != 0 && waited < 40000) begin tick_clk(); waited++; end
        tick_clk();
        mon_on = 0;
        chk(q.size() == 0, tag, "expected steps not all seen", q.size(), 0);
        chk(wraps == 1 + nb, "R9", "wrap pulse count", wraps, 1 + nb);
        chk(iv_err == 0, "R8", "step spacing mismatches", iv_err, 0);
        chk(dir_err == 0, "R11", "direction flag mismatches", dir_err, 0);
        chk(mn == ((b_lo(ka) < b_lo(kb)) ? b_lo(ka) : b_lo(kb)), "R3", "minimum offset", mn, b_lo(kb));
        chk(mx == ((b_hi(ka) > b_hi(kb)) ? b_hi(ka) : b_hi(kb)), "R3", "maximum offset", mx, b_hi(kb));
        ss_en = 1'b0;
        tick_clk();
        chk(ofs == 0, "R2", "offset after disable", ofs, 0);
        tick_clk();
    endtask

    // tick source
    initial begin
        int tc;
        tc = 0; tick = 1'b0;
        forever begin
            @(negedge clk);
            tick = (tc == 0);
            tc = (tc == TDIV - 1) ? 0 : tc + 1;
        end
    end

    // monitor: pops expected values as the offset moves
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on) begin
                int v;
                v = ofs;
                cyc++;
                if (wrap) begin
                    wraps++;
                    chk(v == exp_wrap, "R9", "offset at wrap", v, exp_wrap);
                end
                if (v != prev) begin
                    idx++;
                    if (q.size() == 0) begin
                        chk(1'b0, run_tag, "unexpected offset change", v, prev);
                    end else begin
                        int e;
                        e = q.pop_front();
                        chk(v == e, run_tag, "offset step value", v, e);
                    end
                    if (idx > skip_iv && cyc != iv_exp) iv_err++;
                    if (idx > skip_dir && ((v > prev) != last_rise)) dir_err++;
                    if (v < mn) mn = v;
                    if (v > mx) mx = v;
                    prev = v;
                    cyc = 0;
                end
                last_rise = rising;
            end
        end
    end

    initial begin
        #(CLK_P * 190000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int bad;
        rst = 1'b1; ss_en = 1'b0; kind = 2'b11; pend = 1'b1;
        up_f = 4'd1; dn_f = 4'hF; dwell = 6'd39;
        repeat (5) tick_clk();
        rst = 1'b0;
        tick_clk();
        // R1 reset state
        chk(ofs == 0, "R1", "offset after reset", ofs, 0);
        chk(rising == 1'b0 && wrap == 1'b0, "R1", "flags after reset", {rising, wrap}, 0);

        // R2: disabled, inputs toggling, outputs stay cleared
        bad = 0;
        for (int i = 0; i < 100; i++) begin
            kind = 2'(i); pend = i[1]; up_f = 4'(i); dn_f = 4'(i + 3); dwell = 6'(i % 3);
            tick_clk();
            if (ofs != 0 || rising || wrap) bad++;
        end
        chk(bad == 0, "R2", "outputs moved while disabled", bad, 0);

        // R5 with reset-time settings: +/-0.25% pendulum, unit steps, long dwell
        do_run(3, 1, 1, 15, 39, 3, 1, 1, 15, 0, "R5");
        // R4: 1% down original, up 4, down 1110 (2)
        do_run(0, 0, 4, 14, 1, 0, 0, 4, 14, 1, "R4");
        // R6: 0.5% down original, zero fields mean 16
        do_run(1, 0, 0, 0, 0, 1, 0, 0, 0, 2, "R6");
        // R6 clipping and R7 1000 -> 8: 0.5% center pendulum, up 3
        do_run(2, 1, 3, 8, 2, 2, 1, 3, 8, 1, "R6");
        // R7 0111 -> 9: 0.25% center original, up 5
        do_run(3, 0, 5, 7, 0, 3, 0, 5, 7, 1, "R7");
        // R10: settings changed mid-period take effect at the boundary
        do_run(3, 0, 2, 14, 0, 0, 0, 2, 14, 1, "R10");

        // R2: disable mid-profile then restart
        kind = 2'b00; pend = 1'b0; up_f = 4'd4; dn_f = 4'hE; dwell = 6'd0;
        ss_en = 1'b1;
        repeat (30) tick_clk();
        chk(ofs != 0, "R4", "profile moving before disable", ofs, -1);
        ss_en = 1'b0;
        tick_clk();
        chk(ofs == 0 && !rising, "R2", "offset one clock after disable", ofs, 0);
        ss_en = 1'b1;
        tick_clk();
        chk(ofs == -4 * QU, "R2", "restart at start value", ofs, -4 * QU);
        ss_en = 1'b0;
        repeat (2) tick_clk();

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule